// File: doc/BRIEF.md
# External Pin Interrupt Edge/Level Unit

This unit turns a small group of external input pins into interrupt request lines for a downstream interrupt controller. Pin 0 is reserved. Every other pin can be programmed as a level source, where the request follows the pin while it is held low, or as an edge source that catches rising, falling or both transitions. Every pin passes through a two-flop synchronizer before it is examined. Edge events set a sticky flag that stays set until software clears it by writing a one to that flag bit.

Software drives the unit through a small register bus with a combinational read path. There are four registers: a direction byte, which is brought out as `pin_dir`, a request-enable byte, a trigger-mode word holding one 2-bit field per pin, and the flag byte. A write to the flag byte acknowledges the flags. Each request line is the pin's flag gated by its enable bit. Arbitration between the request lines is left to the interrupt controller that receives them.

Top module: `ep_unit`

## Requirements
- R1: After reset, every register reads zero (address 0 direction, 1 enable, 2 mode, 3 flags), `pin_dir` is zero and no request is asserted.
- R2: A write to address 0 stores the low byte of the write data as the direction register. It reads back at address 0 and appears on `pin_dir`, and it has no effect on requests.
- R3: `irq_req[n]` is high exactly when pin n's flag is set and bit n of the enable register (address 1) is set. The flag itself is still visible at address 3 while the enable bit is clear.
- R4: The mode register (address 2) holds pin n's trigger field at bits [2n+1:2n]: 00 level, 01 rising, 10 falling, 11 both. A write replaces the whole register, and the register reads back exactly as written.
- R5: In rising mode, a 0-to-1 transition of the synchronized pin sets the flag, and a 1-to-0 transition does not.
- R6: In falling mode, only a 1-to-0 transition sets the flag. In both-edges mode, either transition sets it.
- R7: In an edge mode, the flag holds until a write to address 3 has bit n set. Zero bits in that write leave flags unchanged. An edge arriving in the same cycle as the clearing write wins, and the flag stays set.
- R8: In level mode, the flag is the inverse of the synchronized pin, so it is set while the pin is low, and writes to address 3 do not change it.
- R9: A pin change set up before clock edge k first shows in the flag and the request after edge k+2, and not after edge k+1.
- R10: Pin 0 never raises a request, and its flag bit always reads 0, whatever its mode, enable and level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | External pin levels, asynchronous |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address (0 dir, 1 enable, 2 mode, 3 flags) |
| bus_wdata | input | 2*NPINS | Write data |
| bus_rdata | output | 2*NPINS | Combinational read data for `bus_addr` |
| pin_dir | output | NPINS | Direction register contents (0 = input) |
| irq_req | output | NPINS | Request lines to the interrupt controller, bit 0 always low |

## Verification
The bench builds the unit with the default NPINS of 8. That gives seven usable pins plus the reserved one, so rising, falling, both-edges and level pins can run side by side, and one clear write can hit several flags at once. Directed steps pin down the two-cycle synchronizer latency and the case where an edge and a clear land in the same cycle. A randomized phase then mixes pin toggles with mode, enable and clear writes. Throughout both phases, a behavioural model compares the requests and the flag readback with the design on every cycle.

// File: rtl/ep_pkg.sv
package ep_pkg;

  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] REG_DIR  = 2'd0;
  localparam logic [REG_AW-1:0] REG_EN   = 2'd1;
  localparam logic [REG_AW-1:0] REG_MODE = 2'd2;
  localparam logic [REG_AW-1:0] REG_FLAG = 2'd3;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_FALL  = 2'b10,
    TRIG_BOTH  = 2'b11
  } trig_e;

  // Does the transition prev->cur qualify under trigger mode m?
  function automatic logic edge_hit(trig_e m, logic prev, logic cur);
    logic up;
    logic down;
    up   = !prev && cur;
    down = prev && !cur;
    case (m)
      TRIG_RISE: return up;
      TRIG_FALL: return down;
      TRIG_BOTH: return up || down;
      default:   return 1'b0;
    endcase
  endfunction

  // Next flag value: level mode mirrors the active-low pin,
  // edge modes are sticky with edge beating a same-cycle clear.
  function automatic logic next_flag(trig_e m, logic cur, logic hit,
                                     logic clr, logic flag);
    if (m == TRIG_LEVEL) return !cur;
    if (hit)             return 1'b1;
    if (clr)             return 1'b0;
    return flag;
  endfunction

endpackage

// File: rtl/ep_sync.sv
module ep_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage1_q;

  // Idle level of an active-low source is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '1;
      sync_out <= '1;
    end else begin
      stage1_q <= async_in;
      sync_out <= stage1_q;
    end
  end

endmodule

// File: rtl/ep_regs.sv
module ep_regs
  import ep_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [REG_AW-1:0]    bus_addr,
  input  logic [2*NPINS-1:0]   bus_wdata,
  input  logic [NPINS-1:0]     flags_in,
  output logic [NPINS-1:0]     dir_q,
  output logic [NPINS-1:0]     en_q,
  output logic [2*NPINS-1:0]   mode_q,
  output logic [NPINS-1:0]     clr_mask,
  output logic [2*NPINS-1:0]   rdata
);

  localparam int DW = 2 * NPINS;

  logic wr_dir;
  logic wr_en;
  logic wr_mode;
  logic wr_flag;

  assign wr_dir  = bus_wr && (bus_addr == REG_DIR);
  assign wr_en   = bus_wr && (bus_addr == REG_EN);
  assign wr_mode = bus_wr && (bus_addr == REG_MODE);
  assign wr_flag = bus_wr && (bus_addr == REG_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      en_q   <= '0;
      mode_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= bus_wdata[NPINS-1:0];
      if (wr_en)   en_q   <= bus_wdata[NPINS-1:0];
      if (wr_mode) mode_q <= bus_wdata;
    end
  end

  // Write-one-to-clear pulse toward the channels.
  assign clr_mask = wr_flag ? bus_wdata[NPINS-1:0] : '0;

  always_comb begin
    case (bus_addr)
      REG_DIR:  rdata = DW'(dir_q);
      REG_EN:   rdata = DW'(en_q);
      REG_MODE: rdata = mode_q;
      default:  rdata = DW'(flags_in);
    endcase
  end

  a_r2_dir_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (dir_q == $past(bus_wdata[NPINS-1:0])));

  a_r4_mode_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (mode_q == $past(bus_wdata)));

  a_r3_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));

endmodule

// File: rtl/ep_chan.sv
module ep_chan
  import ep_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sync_lvl,
  input  trig_e mode,
  input  logic  clr,
  output logic  flag_q
);

  logic prev_q;
  logic edge_seen;

  assign edge_seen = edge_hit(mode, prev_q, sync_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= sync_lvl;
      flag_q <= next_flag(mode, sync_lvl, edge_seen, clr, flag_q);
    end
  end

  // R5 / R6: a qualifying edge always leaves the flag set
  a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> flag_q);

  a_r7_clear_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != TRIG_LEVEL && clr && !edge_seen) |=> !flag_q);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != TRIG_LEVEL && !clr && !edge_seen) |=> $stable(flag_q));

  a_r8_level_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_LEVEL) |=> (flag_q != $past(sync_lvl)));

endmodule

// File: rtl/ep_unit.sv
module ep_unit
  import ep_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPINS-1:0]     pin_in,
  input  logic                 bus_wr,
  input  logic [1:0]           bus_addr,
  input  logic [2*NPINS-1:0]   bus_wdata,
  output logic [2*NPINS-1:0]   bus_rdata,
  output logic [NPINS-1:0]     pin_dir,
  output logic [NPINS-1:0]     irq_req
);

  // Pin 0 is reserved: it is masked out of flags and requests.
  localparam logic [NPINS-1:0] USABLE = {{(NPINS-1){1'b1}}, 1'b0};

  logic [NPINS-1:0]   sync_lvl;
  logic [NPINS-1:0]   raw_flags;
  logic [NPINS-1:0]   flags;
  logic [NPINS-1:0]   en_q;
  logic [2*NPINS-1:0] mode_q;
  logic [NPINS-1:0]   clr_mask;

  ep_sync #(.W(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (sync_lvl)
  );

  ep_regs #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .flags_in  (flags),
    .dir_q     (pin_dir),
    .en_q      (en_q),
    .mode_q    (mode_q),
    .clr_mask  (clr_mask),
    .rdata     (bus_rdata)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_chan
    ep_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_lvl (sync_lvl[n]),
      .mode     (trig_e'(mode_q[2*n +: 2])),
      .clr      (clr_mask[n]),
      .flag_q   (raw_flags[n])
    );
  end

  assign flags   = raw_flags & USABLE;
  assign irq_req = flags & en_q;

  // R3: no request without its enable bit
  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~en_q) == '0);

  // R10: reserved pin silent (checked against the request port)
  a_r10_pin0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req[0]);

endmodule

// File: tb/tb_ep_unit.sv
`timescale 1ns/1ps
module tb_ep_unit;

  localparam int NP = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   pin_in = '1;
  logic            bus_wr = 1'b0;
  logic [1:0]      bus_addr = 2'd3;
  logic [2*NP-1:0] bus_wdata = '0;
  logic [2*NP-1:0] bus_rdata;
  logic [NP-1:0]   pin_dir;
  logic [NP-1:0]   irq_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  ep_unit #(.NPINS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_dir(pin_dir), .irq_req(irq_req)
  );

  always #2 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit [7:0]  m_s1 = 8'hFF, m_s2 = 8'hFF, m_pv = 8'hFF, m_flag = 8'h00;
  bit [7:0]  m_dir = 8'h00, m_en = 8'h00;
  bit [15:0] m_mode = 16'h0000;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 8'hFF; m_s2 = 8'hFF; m_pv = 8'hFF; m_flag = 8'h00;
      m_dir = 8'h00; m_en = 8'h00; m_mode = 16'h0000;
    end else begin
      bit [7:0]  nf;
      bit [15:0] md_now;
      md_now = m_mode;
      nf = 8'h00;
      for (int n = 1; n < NP; n++) begin
        int md;
        bit cur, pv, rise, fall, hit, clr;
        md   = int'(md_now[2*n +: 2]);
        cur  = m_s2[n];
        pv   = m_pv[n];
        rise = !pv && cur;
        fall = pv && !cur;
        clr  = bus_wr && bus_addr == 2'd3 && bus_wdata[n];
        hit  = (md == 1 && rise) || (md == 2 && fall) || (md == 3 && (rise || fall));
        if (md == 0)  nf[n] = !cur;
        else if (hit) nf[n] = 1'b1;
        else if (clr) nf[n] = 1'b0;
        else          nf[n] = m_flag[n];
      end
      m_flag = nf;
      m_pv = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      if (bus_wr) begin
        case (bus_addr)
          2'd0: m_dir  = bus_wdata[7:0];
          2'd1: m_en   = bus_wdata[7:0];
          2'd2: m_mode = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 model requests", 16'(irq_req), 16'(m_flag & m_en & 8'hFE));
      chk("R2 model direction", 16'(pin_dir), 16'(m_dir));
      if (bus_addr == 2'd3)
        chk("R7 model flags", bus_rdata, 16'(m_flag & 8'hFE));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_w(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0; bus_addr = 2'd3; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); #1;
    bus_addr = a;
    #0.5;
    chk(tag, bus_rdata, exp);
    bus_addr = 2'd3;
  endtask

  task automatic set_pin(input int n, input logic v);
    @(negedge clk); #1;
    pin_in[n] = v;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- directed + random sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_chk(2'd0, 16'h0000, "R1 dir after reset");
    rd_chk(2'd1, 16'h0000, "R1 enable after reset");
    rd_chk(2'd2, 16'h0000, "R1 mode after reset");
    rd_chk(2'd3, 16'h0000, "R1 flags after reset");
    chk("R1 requests after reset", 16'(irq_req), 16'h0000);

    // R2 direction register
    bus_w(2'd0, 16'h00A5);
    rd_chk(2'd0, 16'h00A5, "R2 dir readback");
    #1 chk("R2 pin_dir output", 16'(pin_dir), 16'h00A5);
    chk("R2 no request from dir", 16'(irq_req), 16'h0000);

    // R4 mode fields: pin1 rise, pin2 fall, pin3 both, pin0 both, rest level
    bus_w(2'd2, 16'h00E7);
    rd_chk(2'd2, 16'h00E7, "R4 mode readback");
    bus_w(2'd1, 16'h00FF);

    // R5 falling edge ignored in rising mode
    set_pin(1, 1'b0);
    idle(4);
    #1 chk("R5 fall ignored in rise mode", 16'(irq_req[1]), 16'h0);

    // R9 latency and R5 rising sets
    set_pin(1, 1'b1);
    @(negedge clk);
    @(negedge clk); #1 chk("R9 not yet after k+1", 16'(irq_req[1]), 16'h0);
    @(negedge clk); #1 chk("R9 R5 flag after k+2", 16'(irq_req[1]), 16'h1);

    // R7 sticky, zero-bit write, clear
    set_pin(1, 1'b0);
    idle(4);
    rd_chk(2'd3, 16'h0002, "R7 flag sticky");
    bus_w(2'd3, 16'h0000);
    rd_chk(2'd3, 16'h0002, "R7 zero bits keep flag");
    bus_w(2'd3, 16'h0002);
    rd_chk(2'd3, 16'h0000, "R7 write one clears");

    // R6 falling mode and both mode
    set_pin(2, 1'b0);
    idle(4);
    #1 chk("R6 falling edge sets", 16'(irq_req[2]), 16'h1);
    set_pin(3, 1'b0);
    idle(4);
    #1 chk("R6 both: fall sets", 16'(irq_req[3]), 16'h1);
    bus_w(2'd3, 16'h000C);
    idle(1);
    #1 chk("R6 both cleared", 16'(irq_req[3:2]), 16'h0);
    set_pin(3, 1'b1);
    idle(4);
    #1 chk("R6 both: rise sets", 16'(irq_req[3]), 16'h1);

    // R3 enable gating
    bus_w(2'd1, 16'h0000);
    #1 chk("R3 request gated off", 16'(irq_req), 16'h0000);
    rd_chk(2'd3, 16'h0008, "R3 flag visible while disabled");
    bus_w(2'd1, 16'h00FF);
    bus_w(2'd3, 16'h0008);

    // R7 edge in same cycle as clear wins
    idle(2);
    set_pin(3, 1'b0);
    @(negedge clk);
    bus_w(2'd3, 16'h0008);
    #1 chk("R7 edge beats clear", 16'(irq_req[3]), 16'h1);
    bus_w(2'd3, 16'h0008);

    // R8 level mode on pin 4
    set_pin(4, 1'b0);
    idle(4);
    #1 chk("R8 level low sets", 16'(irq_req[4]), 16'h1);
    bus_w(2'd3, 16'h0010);
    idle(1);
    #1 chk("R8 clear ignored in level", 16'(irq_req[4]), 16'h1);
    set_pin(4, 1'b1);
    idle(4);
    #1 chk("R8 level high drops", 16'(irq_req[4]), 16'h0);

    // R10 reserved pin 0 (mode both, enabled)
    set_pin(0, 1'b0);
    idle(4);
    set_pin(0, 1'b1);
    idle(4);
    rd_chk(2'd3, 16'(irq_req & 8'h00), "R10 pin0 flag zero");
    #1 chk("R10 pin0 no request", 16'(irq_req[0]), 16'h0);

    // randomized mix checked by the model every cycle
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); #1;
      if (($urandom % 4) == 0) pin_in[$urandom % NP] ^= 1'b1;
      if ((i % 25) == 24) begin
        int sel;
        sel = int'($urandom % 3);
        if (sel == 0) bus_w(2'd2, 16'($urandom));
        else if (sel == 1) bus_w(2'd1, 16'($urandom % 256));
        else bus_w(2'd3, 16'($urandom % 256));
      end
    end

    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule